// File: doc/BRIEF.md
# Receiver error status register with enable mask

This block collects the error flags of a digital audio receiver into one sticky status byte. Six error sources are provided by the surrounding receiver logic: Q-subcode CRC, channel-status CRC, PLL unlock, validity, bi-phase coding error and parity. Each source is sampled only on its own framing strobe. A seventh flag, confidence, is derived here from the bi-phase error and the unlock condition.

A per-bit enable mask decides which errors can appear at all. An enabled error that has been sampled stays set until software reads the status byte. That read clears every bit whose source is no longer present.

The block drives a level error output, which is the OR of all held flags. It also drives a one-cycle interrupt request each time any held flag goes from 0 to 1. A simple register port with a one-bit select reaches the status byte (read only) and the mask byte (read/write).

Top module: `rx_err_status`

## Requirements
- R1: After reset the status byte reads 00h, the mask byte reads 00h, and `err_out` and `irq` are 0.
- R2: Both bytes use this layout: bit 6 Q-subcode CRC, bit 5 channel-status CRC, bit 4 unlock, bit 3 validity, bit 2 confidence, bit 1 bi-phase, bit 0 parity. Bit 7 always reads 0, even after writing FFh to the mask. `reg_sel` = 0 selects status and `reg_sel` = 1 selects mask.
- R3: An enabled error sampled on its strobe sets its status bit on the next clock edge. The bit then holds at 1 until a status read.
- R4: Each source is sampled only on its own strobe. Validity, bi-phase, parity and confidence use `strb_subframe`. Unlock and channel-status CRC use `strb_csblk`. Q-subcode CRC uses `strb_qblk`. A source asserted without its strobe sets nothing.
- R5: A status read returns the current byte and then clears each bit whose source is not still true. A bit whose source is still true stays set. An error sampled in the same cycle as the read is set after the read.
- R6: A mask bit of 0 keeps the matching status bit at 0. Clearing a mask bit clears a set status bit on the same edge.
- R7: The confidence error is the OR of the bi-phase error and the unlock condition, sampled on `strb_subframe`.
- R8: The channel-status CRC error sets only while `pro_mode` is 1.
- R9: `err_out` equals the OR of all status bits.
- R10: `irq` pulses high for one cycle in the cycle after any status bit rises from 0 to 1. A bit that is already set raises no new pulse.
- R11: The mask byte is writable and reads back as written. Writes to the status byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_qcrc | input | 1 | Q-subcode CRC error level |
| src_ccrc | input | 1 | Channel-status CRC error level |
| src_unlock | input | 1 | PLL out-of-lock level |
| src_valid | input | 1 | Received validity flag |
| src_biph | input | 1 | Bi-phase coding error level |
| src_par | input | 1 | Parity error level |
| strb_subframe | input | 1 | Sub-frame boundary strobe |
| strb_csblk | input | 1 | Channel-status block boundary strobe |
| strb_qblk | input | 1 | Q-subcode block boundary strobe |
| pro_mode | input | 1 | Professional-mode flag |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| err_out | output | 1 | OR of all held error flags |
| irq | output | 1 | One-cycle pulse on a new error |

## Verification
On every cycle the assertions check four things. Masked-off bits stay clear. A held flag survives until a read, or until its mask drops. A flag kept through a read had its source active. Every rising flag traces back to its own strobe, and to professional mode for the channel-status CRC. The bench scenarios are the only place that shows the read-back values. They also show the bit layout, the write-ignore on the status byte, the collision of a read with a new error, and that repeated errors on an already held bit raise no interrupt.

// File: rtl/rx_err_pkg.sv
// Shared constants for the receiver error status block.
// Assumes a 7-bit flag vector; bit positions are fixed by the register layout.
package rx_err_pkg;
    localparam int NFLAGS = 7;
    localparam int B_PAR    = 0;
    localparam int B_BIPH   = 1;
    localparam int B_CONF   = 2;
    localparam int B_VALID  = 3;
    localparam int B_UNLOCK = 4;
    localparam int B_CCRC   = 5;
    localparam int B_QCRC   = 6;
    typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rx_err_sampler.sv
// Turns raw error levels into per-flag sample events and "still present" levels.
// Assumes strobes are single-cycle and sources are stable around the strobe.
module rx_err_sampler
    import rx_err_pkg::*;
(
    input  logic      src_qcrc,
    input  logic      src_ccrc,
    input  logic      src_unlock,
    input  logic      src_valid,
    input  logic      src_biph,
    input  logic      src_par,
    input  logic      strb_subframe,
    input  logic      strb_csblk,
    input  logic      strb_qblk,
    input  logic      pro_mode,
    output flag_vec_t hit,
    output flag_vec_t active
);
    logic ccrc_lvl;
    logic conf_lvl;

    // Qualify derived levels: CS CRC counts only in pro mode, confidence is BIP|unlock.
    always_comb begin
        ccrc_lvl = src_ccrc & pro_mode;
        conf_lvl = src_biph | src_unlock;
    end

    // Gather current levels into the flag layout.
    always_comb begin
        active           = '0;
        active[B_PAR]    = src_par;
        active[B_BIPH]   = src_biph;
        active[B_CONF]   = conf_lvl;
        active[B_VALID]  = src_valid;
        active[B_UNLOCK] = src_unlock;
        active[B_CCRC]   = ccrc_lvl;
        active[B_QCRC]   = src_qcrc;
    end

    // Sample each level on its own boundary strobe.
    always_comb begin
        hit           = '0;
        hit[B_PAR]    = src_par    & strb_subframe;
        hit[B_BIPH]   = src_biph   & strb_subframe;
        hit[B_CONF]   = conf_lvl   & strb_subframe;
        hit[B_VALID]  = src_valid  & strb_subframe;
        hit[B_UNLOCK] = src_unlock & strb_csblk;
        hit[B_CCRC]   = ccrc_lvl   & strb_csblk;
        hit[B_QCRC]   = src_qcrc   & strb_qblk;
    end
endmodule

// File: rtl/rx_err_sticky.sv
// Bank of sticky flags with enable mask and clear-on-read that spares active sources.
// Assumes mask_next is the mask value taking effect at the coming edge.
module rx_err_sticky #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] active,
    input  logic [W-1:0] mask_next,
    input  logic         clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        logic nxt;

        // Next state: hold or keep-if-active on read, then add new events, then mask.
        always_comb begin
            nxt = clr ? ((q[i] & active[i]) | hit[i]) : (q[i] | hit[i]);
            nxt = nxt & mask_next[i];
        end

        // Flag register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= nxt;
        end

        AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr && mask_next[i]) |=> q[i]); // R3
        AST_READ_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && q[i] && active[i] && mask_next[i]) |=> q[i]); // R5
        AST_KEPT_HAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && q[i] && !active[i] && !hit[i]) |=> !q[i]); // R5
    end
endmodule

// File: rtl/rx_err_irq.sv
// Raises a one-cycle request when any flag rises from 0 to 1.
// Assumes flags come straight from registers.
module rx_err_irq #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags,
    output logic         irq
);
    logic [W-1:0] prev_q;

    // Remember last cycle's flags for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= flags;
    end

    // Pulse on any newly set flag.
    always_comb irq = |(flags & ~prev_q);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0)); // R10
endmodule

// File: rtl/rx_err_status.sv
// Receiver error status top: mask register, sticky status, register port, outputs.
// Assumes reg_rd and reg_wr are single-cycle strobes; read data is combinational.
module rx_err_status
    import rx_err_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_qcrc,
    input  logic              src_ccrc,
    input  logic              src_unlock,
    input  logic              src_valid,
    input  logic              src_biph,
    input  logic              src_par,
    input  logic              strb_subframe,
    input  logic              strb_csblk,
    input  logic              strb_qblk,
    input  logic              pro_mode,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              err_out,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NFLAGS;

    flag_vec_t hit, active, mask_q, mask_d, status_q;
    logic      rd_status;
    logic      unused_wbits;

    // Upper write bits carry no register state.
    always_comb unused_wbits = ^reg_wdata[DATA_W-1:NFLAGS];

    rx_err_sampler u_sampler (
        .src_qcrc      (src_qcrc),
        .src_ccrc      (src_ccrc),
        .src_unlock    (src_unlock),
        .src_valid     (src_valid),
        .src_biph      (src_biph),
        .src_par       (src_par),
        .strb_subframe (strb_subframe),
        .strb_csblk    (strb_csblk),
        .strb_qblk     (strb_qblk),
        .pro_mode      (pro_mode),
        .hit           (hit),
        .active        (active)
    );

    // Mask next-state: load on a mask write, status writes are ignored.
    always_comb begin
        mask_d    = (reg_wr && reg_sel) ? reg_wdata[NFLAGS-1:0] : mask_q;
        rd_status = reg_rd && !reg_sel;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    rx_err_sticky #(.W(NFLAGS)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .active    (active),
        .mask_next (mask_d),
        .clr       (rd_status),
        .q         (status_q)
    );

    rx_err_irq #(.W(NFLAGS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (status_q),
        .irq   (irq)
    );

    // Read mux and combined error level.
    always_comb begin
        reg_rdata = {{PAD_W{1'b0}}, (reg_sel ? mask_q : status_q)};
        err_out   = |status_q;
    end

    AST_MASK_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~mask_q) == '0); // R6
    AST_PAR_ON_SUBFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[B_PAR]) |-> $past(strb_subframe)); // R4
    AST_QCRC_ON_QBLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[B_QCRC]) |-> $past(strb_qblk)); // R4
    AST_CCRC_NEEDS_PRO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[B_CCRC]) |-> $past(pro_mode && strb_csblk)); // R8
    AST_CONF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[B_CONF]) |-> $past(strb_subframe && (src_biph || src_unlock))); // R7
    AST_ERR_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_out) |-> irq); // R10
endmodule

// File: tb/rx_err_status_test.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares at read time.
module rx_err_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_qcrc = 0, src_ccrc = 0, src_unlock = 0, src_valid = 0, src_biph = 0, src_par = 0;
    logic strb_subframe = 0, strb_csblk = 0, strb_qblk = 0, pro_mode = 0;
    logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic err_out, irq;
    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    rx_err_status uut (
        .clk(clk), .rst_n(rst_n),
        .src_qcrc(src_qcrc), .src_ccrc(src_ccrc), .src_unlock(src_unlock),
        .src_valid(src_valid), .src_biph(src_biph), .src_par(src_par),
        .strb_subframe(strb_subframe), .strb_csblk(strb_csblk), .strb_qblk(strb_qblk),
        .pro_mode(pro_mode), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_out(err_out), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pop an expected byte for every read strobe, compare mid-cycle.
    always @(negedge clk) begin
        if (reg_rd && rst_n) begin
            if (exp_q.size() == 0) chk(8'hEE, 8'h00, "scoreboard underflow");
            else chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_sel = sel; reg_rd = 1; step(); reg_rd = 0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
    endtask

    task automatic strobe(input logic sf, input logic cs, input logic qb);
        strb_subframe = sf; strb_csblk = cs; strb_qblk = qb; step();
        strb_subframe = 0; strb_csblk = 0; strb_qblk = 0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        // R1 reset state
        chk({7'd0, err_out}, 8'h00, "R1 err_out");
        chk({7'd0, irq}, 8'h00, "R1 irq");
        rd(0, 8'h00, "R1 status");
        rd(1, 8'h00, "R1 mask");
        // R6 disabled error never appears
        src_par = 1; strobe(1, 0, 0); src_par = 0;
        rd(0, 8'h00, "R6 masked parity");
        // R11 mask write/readback, status write ignored; R2 bit 7 reads 0
        wr(1, 8'hFF);
        rd(1, 8'h7F, "R2 mask bit7 zero");
        wr(0, 8'h55);
        rd(0, 8'h00, "R11 status write ignored");
        // R3 R9 R10 parity sticky, pulse
        src_par = 1; strobe(1, 0, 0); src_par = 0;
        chk({7'd0, irq}, 8'h01, "R10 irq pulse");
        chk({7'd0, err_out}, 8'h01, "R9 err_out set");
        step();
        chk({7'd0, irq}, 8'h00, "R10 irq one cycle");
        repeat (3) step();
        rd(0, 8'h01, "R3 R2 parity bit0 held");
        rd(0, 8'h00, "R5 cleared after read");
        chk({7'd0, err_out}, 8'h00, "R9 err_out clear");
        // R4 validity only on subframe strobe; R5 keep while active
        src_valid = 1; repeat (3) step();
        rd(0, 8'h00, "R4 no strobe");
        strobe(0, 1, 1);
        rd(0, 8'h00, "R4 wrong strobe");
        strobe(1, 0, 0);
        rd(0, 8'h08, "R2 validity bit3");
        rd(0, 8'h08, "R5 kept while active");
        src_valid = 0;
        rd(0, 8'h08, "R5 last read before clear");
        rd(0, 8'h00, "R5 cleared");
        // R7 confidence from bi-phase
        src_biph = 1; strobe(1, 0, 0); src_biph = 0;
        rd(0, 8'h06, "R7 conf from biphase");
        rd(0, 8'h00, "R7 cleared");
        // R7 confidence from unlock, unlock on cs block
        src_unlock = 1; strobe(1, 1, 0);
        rd(0, 8'h14, "R7 conf and unlock");
        src_unlock = 0;
        rd(0, 8'h14, "R5 unlock kept");
        rd(0, 8'h00, "R5 unlock cleared");
        // R8 channel-status CRC needs pro mode
        src_ccrc = 1; strobe(0, 1, 0);
        rd(0, 8'h00, "R8 non-pro ignored");
        pro_mode = 1; strobe(0, 1, 0); src_ccrc = 0;
        rd(0, 8'h20, "R8 pro sets bit5");
        rd(0, 8'h00, "R8 cleared");
        pro_mode = 0;
        // R4 Q-subcode CRC only on Q block
        src_qcrc = 1; strobe(1, 1, 0);
        rd(0, 8'h00, "R4 qcrc wrong strobe");
        strobe(0, 0, 1); src_qcrc = 0;
        rd(0, 8'h40, "R4 qcrc bit6");
        rd(0, 8'h00, "R4 qcrc cleared");
        // R5 event coinciding with read survives
        src_par = 1; strb_subframe = 1;
        rd(0, 8'h00, "R5 collision read value");
        strb_subframe = 0; src_par = 0;
        rd(0, 8'h01, "R5 collision kept");
        // R10 repeated error on held bit gives no pulse
        src_par = 1; strobe(1, 0, 0);
        chk({7'd0, irq}, 8'h01, "R10 first pulse");
        step();
        strobe(1, 0, 0); src_par = 0;
        chk({7'd0, irq}, 8'h00, "R10 no pulse on held bit");
        // R6 dropping mask clears a held bit
        wr(1, 8'h7E);
        rd(0, 8'h00, "R6 mask drop clears");
        chk({7'd0, err_out}, 8'h00, "R6 err_out after mask drop");
        rd(1, 8'h7E, "R11 mask readback");
        repeat (4) step();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule